// File: doc/BRIEF.md
# Multicycle Register-Transfer CPU Sequencer

This block is a small 32-bit register machine that runs every instruction as a series of register-transfer steps. Each step takes one clock. The ALU reads only from two input registers, X and Y, and it writes only to a result register Z. All memory traffic goes through an address register (MAR) and a data register (MDR). A memory access is started in one step and completed in a separate wait step, and the wait step holds the sequencer until the memory answers. The instruction fetch is overlapped with the program-counter increment. The read is issued while the +4 addition runs, and the wait for the instruction word is merged with loading the new PC.

Each instruction has an opcode, a source register and a destination register. Each of the two operands is either register-direct or register-deferred (the register holds a byte address in memory). The result replaces the destination operand. In register mode it goes back into the register file. In deferred mode it goes back to memory at the address held in the register, through MDR and MAR.

Memory uses byte addresses with 4-byte words. Requests follow a strobe/ready handshake.

Top module: `cpu_seq_core`

## Requirements
- R1: After a synchronous active-low reset, PC, MAR, MDR and all general registers are 0, both strobes are low, and the first access the core makes is an instruction read at address 0.
- R2: Every instruction starts with a read at the current PC, and the PC advances by 4 for each instruction. The returned word becomes the instruction.
- R3: The instruction takes a fixed number of cycles, counted from the start of one fetch read to the start of the next, where d is the number of cycles the ready signal arrives after the first cycle the strobe is seen:
  - The fetch costs 6 + max(0, d-1) cycles. The fetch wait overlaps the add, so d ≤ 1 costs nothing extra.
  - A valid opcode adds 3 cycles.
  - A deferred source read adds 3 + d cycles.
  - A deferred destination adds 3 + d cycles for its read and 2 + d cycles for its write.
- R4: Instruction fields:
  - bits [31:28] are the opcode.
  - bit 27 is set for a deferred source, and bits [26:24] are the source register.
  - bit 23 is set for a deferred destination, and bits [22:20] are the destination register.
  - Opcode 0 gives dst = dst + src. Opcode 1 gives dst = dst - src. Opcode 2 gives dst = dst - 1, and its source is never read.
- R5: A register-mode source comes from the register file. A deferred source is read from memory at the address held in the source register, before any destination access.
- R6: A register-mode destination is written back into the register file. A deferred destination is first read from memory at the address held in the destination register.
- R7: Read and write strobes are never high together, and at most one access is outstanding. A strobe stays high with a stable address and write data until ready is seen. A wait step does not advance before ready.
- R8: Opcodes 3 to 15 perform no memory access beyond their fetch and change no register.
- R9: A deferred destination ends with one write. Its address is the value in the destination register and its data is the ALU result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_ready | input | 1 | One-cycle completion pulse for the outstanding access |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_addr | output | 32 | Byte address (contents of MAR) |
| mem_wdata | output | 32 | Write data (contents of MDR) |
| mem_rd | output | 1 | Read strobe, held until ready |
| mem_wr | output | 1 | Write strobe, held until ready |

## Verification
The main function is driven with random programs in which the operand modes and the three valid opcodes are mixed with invalid opcodes. Each program is run under three fixed memory latencies and then under random per-access latency. The zero-latency and one-latency runs give the same fetch cost, which separates a fetch wait that overlaps the add from one that is serialized after it. The three-latency run exposes each non-overlapped wait step individually. The random-latency run checks that the result never depends on when ready arrives. A reference interpreter predicts every access address, every write value and every instruction's cycle count, so a wrong operand order, a source read for a decrement, or a skipped write-back each shows up as a mismatched access.

// File: rtl/cpu_seq_pkg.sv
// Package: shared step encoding, ALU operations and opcode values for the
// register-transfer sequencer. Assumes a 4-bit opcode at the top of the word.
package cpu_seq_pkg;

    typedef enum logic [4:0] {
        ST_F0_PC,     // PC -> MAR, X
        ST_F1_RD,     // start read; 4 -> Y
        ST_F2_ADD,    // add
        ST_F3_WT,     // Z -> PC; wait
        ST_F4_IR,     // MDR -> IR
        ST_DEC,       // decode, source register or source address
        ST_SRC_RD,    // start source read
        ST_SRC_WT,    // wait source
        ST_SRC_LD,    // MDR -> Y
        ST_DSEL,      // destination register or destination address
        ST_DST_RD,    // start destination read
        ST_DST_WT,    // wait destination
        ST_DST_LD,    // MDR -> X
        ST_EXEC,      // ALU -> Z
        ST_STORE,     // Z -> register, or Z -> MDR and address -> MAR
        ST_WR,        // start write
        ST_WR_WT      // wait write
    } step_e;

    typedef enum logic {ALU_ADD, ALU_SUB} alu_op_e;

    localparam logic [3:0] OPC_ADD = 4'd0;
    localparam logic [3:0] OPC_SUB = 4'd1;
    localparam logic [3:0] OPC_DEC = 4'd2;

endpackage

// File: rtl/cpu_seq_regfile.sv
// General register file: one write port, two combinational read ports.
// Assumes synchronous active-low reset clears every register to zero.
module cpu_seq_regfile #(
    parameter int DATA_W = 32,
    parameter int REG_N  = 8,
    localparam int IDX_W = $clog2(REG_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [IDX_W-1:0]  raddr_b,
    output logic [DATA_W-1:0] rdata_b
);
    logic [DATA_W-1:0] regs [REG_N];

    for (genvar g = 0; g < REG_N; g++) begin : g_reg
        // Hold one register; cleared on reset, loaded when addressed
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (we && waddr == IDX_W'(g))
                regs[g] <= wdata;
        end
    end

    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];
endmodule

// File: rtl/cpu_seq_alu.sv
// ALU: operands come only from X and Y; the result is meant for Z.
// Purely combinational.
module cpu_seq_alu #(
    parameter int DATA_W = 32
) (
    input  cpu_seq_pkg::alu_op_e op,
    input  logic [DATA_W-1:0]    a,
    input  logic [DATA_W-1:0]    b,
    output logic [DATA_W-1:0]    y
);
    // Select sum or difference
    always_comb begin
        if (op == cpu_seq_pkg::ALU_SUB)
            y = a - b;
        else
            y = a + b;
    end
endmodule

// File: rtl/cpu_seq_memport.sv
// Memory handshake: a start pulse raises the read or write strobe, which
// stays high until ready. Assumes the sequencer never starts a second
// access while one is outstanding.
module cpu_seq_memport (
    input  logic clk,
    input  logic rst_n,
    input  logic start_rd,
    input  logic start_wr,
    input  logic mem_ready,
    output logic mem_rd,
    output logic mem_wr,
    output logic busy,
    output logic done
);
    assign busy = mem_rd | mem_wr;
    assign done = mem_ready & busy;

    // Track the outstanding access strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_rd <= 1'b0;
            mem_wr <= 1'b0;
        end else if (done) begin
            mem_rd <= 1'b0;
            mem_wr <= 1'b0;
        end else begin
            if (start_rd) mem_rd <= 1'b1;
            if (start_wr) mem_wr <= 1'b1;
        end
    end
endmodule

// File: rtl/cpu_seq_core.sv
// Multicycle register machine: one register-transfer step per clock.
// The fetch overlaps the PC increment. Operands are register-direct or
// register-deferred. The ALU reads X and Y and writes Z. Memory goes
// through MAR/MDR. Assumes a byte-addressed memory with PC_STEP-byte words.
module cpu_seq_core #(
    parameter int DATA_W  = 32,
    parameter int REG_N   = 8,
    parameter int PC_STEP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_rd,
    output logic              mem_wr
);
    import cpu_seq_pkg::*;

    localparam int RIDX_W   = $clog2(REG_N);
    localparam int OPC_LSB  = DATA_W - 4;
    localparam int SMODE    = OPC_LSB - 1;
    localparam int SREG_LSB = SMODE - RIDX_W;
    localparam int DMODE    = SREG_LSB - 1;
    localparam int DREG_LSB = DMODE - RIDX_W;

    step_e state, nstate;
    logic [DATA_W-1:0] pc, ir, x, y, z, mar, mdr;
    logic [DATA_W-1:0] alu_y, rf_a, rf_b;
    logic [3:0]        opc;
    logic              src_def, dst_def, op_valid;
    logic [RIDX_W-1:0] src_idx, dst_idx;
    logic              start_rd, start_wr, mp_busy, mp_done, wait_ok, rf_we;
    alu_op_e           alu_op;

    assign opc      = ir[DATA_W-1:OPC_LSB];
    assign src_def  = ir[SMODE];
    assign src_idx  = ir[SMODE-1:SREG_LSB];
    assign dst_def  = ir[DMODE];
    assign dst_idx  = ir[DMODE-1:DREG_LSB];
    assign op_valid = (opc == OPC_ADD) || (opc == OPC_SUB) || (opc == OPC_DEC);

    assign start_rd = (state == ST_F1_RD) || (state == ST_SRC_RD) || (state == ST_DST_RD);
    assign start_wr = (state == ST_WR);
    assign wait_ok  = !mp_busy || mp_done;
    assign rf_we    = (state == ST_STORE) && !dst_def;
    assign alu_op   = (state == ST_EXEC && opc != OPC_ADD) ? ALU_SUB : ALU_ADD;

    assign mem_addr  = mar;
    assign mem_wdata = mdr;

    cpu_seq_regfile #(.DATA_W(DATA_W), .REG_N(REG_N)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(dst_idx), .wdata(z),
        .raddr_a(src_idx), .rdata_a(rf_a), .raddr_b(dst_idx), .rdata_b(rf_b)
    );

    cpu_seq_alu #(.DATA_W(DATA_W)) u_alu (
        .op(alu_op), .a(x), .b(y), .y(alu_y)
    );

    cpu_seq_memport u_mp (
        .clk(clk), .rst_n(rst_n), .start_rd(start_rd), .start_wr(start_wr),
        .mem_ready(mem_ready), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .busy(mp_busy), .done(mp_done)
    );

    // Choose the next step from the current step, decode and memory state
    always_comb begin
        nstate = state;
        unique case (state)
            ST_F0_PC:  nstate = ST_F1_RD;
            ST_F1_RD:  nstate = ST_F2_ADD;
            ST_F2_ADD: nstate = ST_F3_WT;
            ST_F3_WT:  if (wait_ok) nstate = ST_F4_IR;
            ST_F4_IR:  nstate = ST_DEC;
            ST_DEC:    if (!op_valid)                      nstate = ST_F0_PC;
                       else if (opc == OPC_DEC || !src_def) nstate = ST_DSEL;
                       else                                nstate = ST_SRC_RD;
            ST_SRC_RD: nstate = ST_SRC_WT;
            ST_SRC_WT: if (wait_ok) nstate = ST_SRC_LD;
            ST_SRC_LD: nstate = ST_DSEL;
            ST_DSEL:   nstate = dst_def ? ST_DST_RD : ST_EXEC;
            ST_DST_RD: nstate = ST_DST_WT;
            ST_DST_WT: if (wait_ok) nstate = ST_DST_LD;
            ST_DST_LD: nstate = ST_EXEC;
            ST_EXEC:   nstate = ST_STORE;
            ST_STORE:  nstate = dst_def ? ST_WR : ST_F0_PC;
            ST_WR:     nstate = ST_WR_WT;
            ST_WR_WT:  if (wait_ok) nstate = ST_F0_PC;
            default:   nstate = ST_F0_PC;
        endcase
    end

    // Advance the step register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_F0_PC;
        else        state <= nstate;
    end

    // Perform the register transfers of the current step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc  <= '0;
            ir  <= '0;
            x   <= '0;
            y   <= '0;
            z   <= '0;
            mar <= '0;
            mdr <= '0;
        end else begin
            if (mp_done && mem_rd) mdr <= mem_rdata;
            unique case (state)
                ST_F0_PC:  begin mar <= pc; x <= pc; end
                ST_F1_RD:  y <= DATA_W'(PC_STEP);
                ST_F2_ADD: z <= alu_y;
                ST_F3_WT:  pc <= z;
                ST_F4_IR:  ir <= mdr;
                ST_DEC: begin
                    if (opc == OPC_DEC) y   <= DATA_W'(1);
                    else if (!src_def)  y   <= rf_a;
                    else                mar <= rf_a;
                end
                ST_SRC_LD: y <= mdr;
                ST_DSEL:   if (dst_def) mar <= rf_b; else x <= rf_b;
                ST_DST_LD: x <= mdr;
                ST_EXEC:   z <= alu_y;
                ST_STORE:  if (dst_def) begin mdr <= z; mar <= rf_b; end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cpu_seq_chk.sv
// Checker for the sequencer: handshake rules, wait stalls and PC advance.
// Bound to every instance of the top module.
module cpu_seq_chk #(
    parameter int DATA_W  = 32,
    parameter int PC_STEP = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                mem_ready,
    input logic                mem_rd,
    input logic                mem_wr,
    input logic [DATA_W-1:0]   mem_addr,
    input logic [DATA_W-1:0]   mem_wdata,
    input cpu_seq_pkg::step_e  state,
    input logic [DATA_W-1:0]   pc
);
    import cpu_seq_pkg::*;

    logic in_wait;
    assign in_wait = (state == ST_F3_WT) || (state == ST_SRC_WT) ||
                     (state == ST_DST_WT) || (state == ST_WR_WT);

    // R1
    reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !mem_rd && !mem_wr);

    // R7
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R7
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd && !mem_ready |=> mem_rd && $stable(mem_addr));

    // R7
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr && !mem_ready |=> mem_wr && $stable(mem_addr) && $stable(mem_wdata));

    // R7
    wait_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_wait && (mem_rd || mem_wr) && !mem_ready |=> $stable(state));

    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_F4_IR |-> pc == mem_addr + DATA_W'(PC_STEP));
endmodule

bind cpu_seq_core cpu_seq_chk #(.DATA_W(DATA_W), .PC_STEP(PC_STEP)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_ready(mem_ready), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .state(state), .pc(pc)
);

// File: tb/sim_cpu_seq_core.sv
// Bench: random programs with fixed-seed $urandom plus directed opening
// words. A reference interpreter predicts every access and cycle count.
module sim_cpu_seq_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_rd, mem_wr;

    always #2 clk = ~clk;

    cpu_seq_core u0 (
        .clk(clk), .rst_n(rst_n), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr)
    );

    int checks = 0, errors = 0;
    logic [31:0] mem [64];
    logic [31:0] ref_mem [64];
    logic [31:0] ref_r [8];
    logic [31:0] ref_pc;

    // expected accesses of the current instruction
    bit          e_wr [4];
    logic [31:0] e_addr [4];
    logic [31:0] e_data [4];
    string       e_tag [4];
    int          e_len = 0, e_idx = 0;

    int  cyc = 0, last_fetch = 0, prev_cyc = 0, ninstr = 0, cur_d = 0, wcnt = 0;
    bit  run = 0, serving = 0, have_prev = 0, prev_timed = 0, prev_bad = 0, timed = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int op, input bit sd, input int sr, input bit dd, input int dr);
        return {4'(op), sd, 3'(sr), dd, 3'(dr), 20'h0};
    endfunction

    task automatic push(input bit wr, input logic [31:0] a, input logic [31:0] d, input string tag);
        e_wr[e_len] = wr; e_addr[e_len] = a; e_data[e_len] = d; e_tag[e_len] = tag;
        e_len++;
    endtask

    // Reference interpreter: one instruction, its accesses and its cycle cost
    task automatic model_next(input int d);
        logic [31:0] w, a, b, res;
        int op, sr, dr;
        w = ref_mem[ref_pc[7:2]];
        e_len = 0; e_idx = 0;
        push(0, ref_pc, 0, ninstr == 1 ? "R1" : "R2");
        ref_pc += 4;
        prev_cyc = 6 + (d > 1 ? d - 1 : 0);
        op = int'(w[31:28]); sr = int'(w[26:24]); dr = int'(w[22:20]);
        prev_bad = (op > 2);
        if (op <= 2) begin
            prev_cyc += 3;
            if (op == 2) b = 32'd1;
            else if (w[27]) begin
                push(0, ref_r[sr], 0, "R5");
                b = ref_mem[ref_r[sr][7:2]];
                prev_cyc += 3 + d;
            end else b = ref_r[sr];
            if (w[23]) begin
                push(0, ref_r[dr], 0, "R6");
                a = ref_mem[ref_r[dr][7:2]];
                prev_cyc += 3 + d;
            end else a = ref_r[dr];
            res = (op == 0) ? a + b : a - b;
            if (w[23]) begin
                push(1, ref_r[dr], res, "R9");
                ref_mem[ref_r[dr][7:2]] = res;
                prev_cyc += 2 + d;
            end else ref_r[dr] = res;
        end
    endtask

    // Memory responder and access checker
    always @(negedge clk) begin
        mem_ready = 1'b0;
        if (rst_n && run) begin
            cyc++;
            if (!serving && (mem_rd || mem_wr)) begin
                if (e_idx == e_len) begin
                    if (have_prev && prev_timed)
                        chk(cyc - last_fetch == prev_cyc, prev_bad ? "R8 cycles" : "R3 cycles",
                            32'(cyc - last_fetch), 32'(prev_cyc));
                    last_fetch = cyc;
                    have_prev = 1;
                    ninstr++;
                    timed = (ninstr <= 300);
                    cur_d = ninstr <= 100 ? 0 : (ninstr <= 200 ? 1 : 3);
                    prev_timed = timed;
                    model_next(timed ? cur_d : 0);
                end
                if (e_idx < e_len) begin
                    chk(mem_wr == e_wr[e_idx], e_tag[e_idx], 32'(mem_wr), 32'(e_wr[e_idx]));
                    chk(mem_addr == e_addr[e_idx], e_tag[e_idx], mem_addr, e_addr[e_idx]);
                    if (e_wr[e_idx]) chk(mem_wdata == e_data[e_idx], "R4 result", mem_wdata, e_data[e_idx]);
                    e_idx++;
                end else begin
                    chk(0, "R8 extra access", mem_addr, 0);
                end
                serving = 1;
                wcnt = timed ? cur_d : int'($urandom_range(0, 4));
            end
            if (serving) begin
                if (wcnt == 0) begin
                    if (mem_rd) mem_rdata = mem[mem_addr[7:2]];
                    else        mem[mem_addr[7:2]] = mem_wdata;
                    mem_ready = 1'b1;
                    serving = 0;
                end else begin
                    chk(mem_rd || mem_wr, "R7 strobe held", 32'(mem_rd | mem_wr), 1);
                    wcnt--;
                end
            end
        end
    end

    initial begin
        int seed;
        seed = 11;
        void'($urandom(seed));
        for (int i = 0; i < 64; i++) begin
            int k;
            k = int'($urandom_range(0, 5));
            mem[i] = $urandom();
            if (k <= 4) mem[i][31:28] = 4'(k % 3);
        end
        // directed opening: zero registers, decrement, subtract, deferred paths, bad opcode
        mem[0] = mk(0, 0, 2, 1, 1);
        mem[1] = mk(2, 1, 7, 0, 3);
        mem[2] = mk(1, 0, 3, 0, 4);
        mem[3] = mk(0, 1, 4, 1, 3);
        mem[4] = mk(9, 1, 1, 1, 1);
        mem[5] = mk(2, 0, 0, 1, 4);
        for (int i = 0; i < 64; i++) ref_mem[i] = mem[i];
        for (int i = 0; i < 8; i++) ref_r[i] = '0;
        ref_pc = '0;

        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(!mem_rd && !mem_wr, "R1 strobes", 32'({mem_rd, mem_wr}), 0);
        chk(mem_addr == 0, "R1 address", mem_addr, 0);
        rst_n = 1'b1;
        run = 1;
        wait (ninstr >= 500);
        @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected<%0d", ninstr, 500);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule